// File: doc/BRIEF.md
# Static Dataflow Firing Unit

This block runs a small static dataflow program held on chip. Each of its eight entries describes one instruction: an operation, two operand slots that each carry a present flag, up to two result destinations, and, for each operand slot, the place its acknowledge must go. Values come in as tokens. A token holds a 16-bit value and a slot address, and has no tag or context. When an entry has every operand it needs, and every destination has confirmed that it used the previous result, the entry fires. Firing computes the result, sends it to the destinations and acknowledges the operands it consumed to their producers. Because of this acknowledge discipline, no arc ever holds more than one token.

Destinations and producers can be internal entries or outside agents. A result bound for another entry is written straight into that entry's operand slot. A result bound outside leaves on an output token channel. Acknowledges between entries are handled inside the block. Acknowledges to or from outside agents use dedicated ports. A write port loads the program. At most one entry fires per cycle, chosen in rotating order.

Top module: `dfa_unit`

## Requirements
- R1: A load (`ld_vld`) writes entry `ld_tpl` and clears its present and outstanding flags. Destination fields are laid out as bit 5 = valid, bit 4 = external, bits 3:0 = slot address. Producer fields are laid out as bit 4 = internal, bits 3:1 = producer entry, bit 0 = which of the producer's destinations. A freshly loaded entry is not enabled in the following cycle.
- R2: A slot address is {entry, port}, with port 0 as operand A and port 1 as operand B. An input token addressed to an empty slot stores the value and marks the slot present. A token addressed to a slot that is already present is ignored, and the stored value is kept.
- R3: An entry is enabled when operand A is present, operand B is also present (except for PASS, which uses only A), and no valid destination has an outstanding bit. An entry with a missing operand never fires.
- R4: The operation codes are ADD=0, SUB=1, AND=2, OR=3 and PASS=4 (result A). Arithmetic wraps modulo 2^16.
- R5: When an entry fires at a clock edge, `fire_vld`, `fire_tpl` and `fire_res` show that fire in the next cycle. Each valid external destination k raises `tout_vld[k]`, with its address on `tout_addrk` and the result on `tout_val`.
- R6: A valid internal destination writes the result into the target slot at the firing edge. The target entry can therefore fire at the very next edge.
- R7: Firing frees the consumed operand slots. For each consumed slot with an internal producer, the producer's outstanding bit is cleared. For each consumed slot with an external producer, `aout_vld[port]` is raised and `aout_tpl` carries the firing entry.
- R8: Firing sets the outstanding bit of each valid destination. An external destination's bit is cleared only by `ain_vld` naming that entry and destination. While the bit is set, the entry does not fire again.
- R9: At most one entry fires per cycle. The search starts at the entry just after the last one that fired and wraps around.
- R10: A synchronous active-high reset clears all entries, all flags, the rotation pointer and every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_vld | input | 1 | Program entry write strobe |
| ld_tpl | input | 3 | Entry being written |
| ld_op | input | 3 | Operation code |
| ld_dst0 | input | 6 | Destination 0 {valid, external, slot} |
| ld_dst1 | input | 6 | Destination 1 {valid, external, slot} |
| ld_src0 | input | 5 | Operand A producer {internal, entry, dest} |
| ld_src1 | input | 5 | Operand B producer {internal, entry, dest} |
| tin_vld | input | 1 | Input token strobe |
| tin_slot | input | 4 | Input token slot address |
| tin_val | input | 16 | Input token value |
| ain_vld | input | 1 | External acknowledge strobe |
| ain_tpl | input | 3 | Entry being acknowledged |
| ain_dn | input | 1 | Destination being acknowledged |
| fire_vld | output | 1 | An entry fired at the last edge |
| fire_tpl | output | 3 | Entry that fired |
| fire_res | output | 16 | Result of that fire |
| tout_vld | output | 2 | External result token per destination |
| tout_addr0 | output | 4 | Address for destination 0 |
| tout_addr1 | output | 4 | Address for destination 1 |
| tout_val | output | 16 | Result token value |
| aout_vld | output | 2 | External acknowledge per operand port |
| aout_tpl | output | 3 | Entry issuing the acknowledge |

## Verification
On every cycle, the assertions check that a granted entry is actually enabled. They also check that an internal result lands only in an empty slot, which is the one-token-per-arc rule. Two further checks are that a just-loaded entry is idle, and that an entry whose external result is still unacknowledged is not granted again. Only the bench scenarios can show the operation results and the ignoring of a second token into a full slot. The same holds for internal acknowledges freeing a producer, chained firing on consecutive edges, and the rotating order when two consumers become ready together.

// File: rtl/dfa_pkg.sv
package dfa_pkg;

    localparam int TPL_N  = 8;
    localparam int DATA_W = 16;
    localparam int TPL_W  = $clog2(TPL_N);
    localparam int SLOT_W = TPL_W + 1;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_PASS = 3'd4
    } op_e;

    typedef struct packed {
        logic              vld;
        logic              ext;
        logic [SLOT_W-1:0] addr;
    } dst_t;

    typedef struct packed {
        logic             intl;
        logic [TPL_W-1:0] tpl;
        logic             dn;
    } src_t;

    typedef struct packed {
        op_e  op;
        dst_t d0;
        dst_t d1;
        src_t s0;
        src_t s1;
    } tpl_t;

    function automatic logic needs_b(op_e op);
        return op != OP_PASS;
    endfunction

endpackage

// File: rtl/dfa_alu.sv
module dfa_alu
    import dfa_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/dfa_rr_arb.sv
module dfa_rr_arb #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic         gnt_vld,
    output logic [W-1:0] gnt_idx
);

    logic [W-1:0] ptr;
    logic [W-1:0] cand;

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        cand    = '0;
        for (int k = 0; k < N; k++) begin
            cand = ptr + W'(k);
            if (!gnt_vld && req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (gnt_vld) begin
            ptr <= gnt_idx + 1'b1;
        end
    end

    // R9: a grant only ever goes to a requesting entry
    p_gnt_req_r9: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> req[gnt_idx]);

endmodule

// File: rtl/dfa_tpl_store.sv
module dfa_tpl_store
    import dfa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_vld,
    input  logic [TPL_W-1:0]  ld_tpl,
    input  tpl_t              ld_cfg,
    input  logic              tin_vld,
    input  logic [SLOT_W-1:0] tin_slot,
    input  logic [DATA_W-1:0] tin_val,
    input  logic              ain_vld,
    input  logic [TPL_W-1:0]  ain_tpl,
    input  logic              ain_dn,
    input  logic              fire_vld,
    input  logic [TPL_W-1:0]  fire_tpl,
    input  logic [DATA_W-1:0] fire_res,
    output logic [TPL_N-1:0]  en,
    output tpl_t              sel_cfg,
    output logic [DATA_W-1:0] sel_a,
    output logic [DATA_W-1:0] sel_b
);

    tpl_t              cfg  [TPL_N];
    logic [1:0]        pres [TPL_N];
    logic [1:0]        outs [TPL_N];
    logic [DATA_W-1:0] opnd [TPL_N][2];

    generate
        for (genvar i = 0; i < TPL_N; i++) begin : g_en
            assign en[i] = pres[i][0]
                         & (pres[i][1] | ~needs_b(cfg[i].op))
                         & ~(outs[i][0] & cfg[i].d0.vld)
                         & ~(outs[i][1] & cfg[i].d1.vld);
        end
    endgenerate

    assign sel_cfg = cfg[fire_tpl];
    assign sel_a   = opnd[fire_tpl][0];
    assign sel_b   = opnd[fire_tpl][1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TPL_N; i++) begin
                cfg[i]     <= '0;
                pres[i]    <= '0;
                outs[i]    <= '0;
                opnd[i][0] <= '0;
                opnd[i][1] <= '0;
            end
        end else begin
            if (tin_vld && !pres[tin_slot[SLOT_W-1:1]][tin_slot[0]]) begin
                pres[tin_slot[SLOT_W-1:1]][tin_slot[0]] <= 1'b1;
                opnd[tin_slot[SLOT_W-1:1]][tin_slot[0]] <= tin_val;
            end
            if (ain_vld) begin
                outs[ain_tpl][ain_dn] <= 1'b0;
            end
            if (fire_vld) begin
                pres[fire_tpl][0] <= 1'b0;
                if (needs_b(sel_cfg.op)) pres[fire_tpl][1] <= 1'b0;
                if (sel_cfg.d0.vld) outs[fire_tpl][0] <= 1'b1;
                if (sel_cfg.d1.vld) outs[fire_tpl][1] <= 1'b1;
                if (sel_cfg.s0.intl) outs[sel_cfg.s0.tpl][sel_cfg.s0.dn] <= 1'b0;
                if (needs_b(sel_cfg.op) && sel_cfg.s1.intl)
                    outs[sel_cfg.s1.tpl][sel_cfg.s1.dn] <= 1'b0;
                if (sel_cfg.d0.vld && !sel_cfg.d0.ext) begin
                    pres[sel_cfg.d0.addr[SLOT_W-1:1]][sel_cfg.d0.addr[0]] <= 1'b1;
                    opnd[sel_cfg.d0.addr[SLOT_W-1:1]][sel_cfg.d0.addr[0]] <= fire_res;
                end
                if (sel_cfg.d1.vld && !sel_cfg.d1.ext) begin
                    pres[sel_cfg.d1.addr[SLOT_W-1:1]][sel_cfg.d1.addr[0]] <= 1'b1;
                    opnd[sel_cfg.d1.addr[SLOT_W-1:1]][sel_cfg.d1.addr[0]] <= fire_res;
                end
            end
            if (ld_vld) begin
                cfg[ld_tpl]  <= ld_cfg;
                pres[ld_tpl] <= '0;
                outs[ld_tpl] <= '0;
            end
        end
    end

    // R3: a fire is only issued for an entry whose operands and acks allow it
    p_fire_enabled_r3: assert property (@(posedge clk) disable iff (rst)
        fire_vld |-> en[fire_tpl]);

    // R6: an internal result never lands on a slot that still holds a token
    p_one_tok_arc_r6: assert property (@(posedge clk) disable iff (rst)
        (fire_vld && sel_cfg.d0.vld && !sel_cfg.d0.ext)
        |-> !pres[sel_cfg.d0.addr[SLOT_W-1:1]][sel_cfg.d0.addr[0]]);

    // R1: a freshly loaded entry starts idle
    p_ld_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (ld_vld && !tin_vld) |=> !en[$past(ld_tpl)]);

endmodule

// File: rtl/dfa_unit.sv
module dfa_unit
    import dfa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_vld,
    input  logic [TPL_W-1:0]  ld_tpl,
    input  logic [2:0]        ld_op,
    input  logic [SLOT_W+1:0] ld_dst0,
    input  logic [SLOT_W+1:0] ld_dst1,
    input  logic [TPL_W+1:0]  ld_src0,
    input  logic [TPL_W+1:0]  ld_src1,
    input  logic              tin_vld,
    input  logic [SLOT_W-1:0] tin_slot,
    input  logic [DATA_W-1:0] tin_val,
    input  logic              ain_vld,
    input  logic [TPL_W-1:0]  ain_tpl,
    input  logic              ain_dn,
    output logic              fire_vld,
    output logic [TPL_W-1:0]  fire_tpl,
    output logic [DATA_W-1:0] fire_res,
    output logic [1:0]        tout_vld,
    output logic [SLOT_W-1:0] tout_addr0,
    output logic [SLOT_W-1:0] tout_addr1,
    output logic [DATA_W-1:0] tout_val,
    output logic [1:0]        aout_vld,
    output logic [TPL_W-1:0]  aout_tpl
);

    tpl_t              ld_cfg;
    tpl_t              sel_cfg;
    logic [TPL_N-1:0]  en;
    logic              gnt_vld;
    logic [TPL_W-1:0]  gnt_idx;
    logic [DATA_W-1:0] opa, opb, alu_y;

    always_comb begin
        ld_cfg.op = op_e'(ld_op);
        ld_cfg.d0 = dst_t'(ld_dst0);
        ld_cfg.d1 = dst_t'(ld_dst1);
        ld_cfg.s0 = src_t'(ld_src0);
        ld_cfg.s1 = src_t'(ld_src1);
    end

    dfa_tpl_store u_store (
        .clk      (clk),
        .rst      (rst),
        .ld_vld   (ld_vld),
        .ld_tpl   (ld_tpl),
        .ld_cfg   (ld_cfg),
        .tin_vld  (tin_vld),
        .tin_slot (tin_slot),
        .tin_val  (tin_val),
        .ain_vld  (ain_vld),
        .ain_tpl  (ain_tpl),
        .ain_dn   (ain_dn),
        .fire_vld (gnt_vld),
        .fire_tpl (gnt_idx),
        .fire_res (alu_y),
        .en       (en),
        .sel_cfg  (sel_cfg),
        .sel_a    (opa),
        .sel_b    (opb)
    );

    dfa_rr_arb #(.N(TPL_N)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (en),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    dfa_alu u_alu (
        .op (sel_cfg.op),
        .a  (opa),
        .b  (opb),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fire_vld   <= 1'b0;
            fire_tpl   <= '0;
            fire_res   <= '0;
            tout_vld   <= '0;
            tout_addr0 <= '0;
            tout_addr1 <= '0;
            tout_val   <= '0;
            aout_vld   <= '0;
            aout_tpl   <= '0;
        end else begin
            fire_vld    <= gnt_vld;
            fire_tpl    <= gnt_idx;
            fire_res    <= alu_y;
            tout_vld[0] <= gnt_vld & sel_cfg.d0.vld & sel_cfg.d0.ext;
            tout_vld[1] <= gnt_vld & sel_cfg.d1.vld & sel_cfg.d1.ext;
            tout_addr0  <= sel_cfg.d0.addr;
            tout_addr1  <= sel_cfg.d1.addr;
            tout_val    <= alu_y;
            aout_vld[0] <= gnt_vld & ~sel_cfg.s0.intl;
            aout_vld[1] <= gnt_vld & needs_b(sel_cfg.op) & ~sel_cfg.s1.intl;
            aout_tpl    <= gnt_idx;
        end
    end

    // R8: an entry whose external result was just sent cannot be granted again
    p_no_refire_r8: assert property (@(posedge clk) disable iff (rst)
        (fire_vld && tout_vld[0]) |-> !(gnt_vld && gnt_idx == fire_tpl));

endmodule

// File: tb/dfa_unit_tb.sv
module dfa_unit_tb;
    import dfa_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_vld = 1'b0;
    logic [TPL_W-1:0]  ld_tpl = '0;
    logic [2:0]        ld_op = '0;
    logic [SLOT_W+1:0] ld_dst0 = '0, ld_dst1 = '0;
    logic [TPL_W+1:0]  ld_src0 = '0, ld_src1 = '0;
    logic              tin_vld = 1'b0;
    logic [SLOT_W-1:0] tin_slot = '0;
    logic [DATA_W-1:0] tin_val = '0;
    logic              ain_vld = 1'b0;
    logic [TPL_W-1:0]  ain_tpl = '0;
    logic              ain_dn = 1'b0;
    logic              fire_vld;
    logic [TPL_W-1:0]  fire_tpl;
    logic [DATA_W-1:0] fire_res;
    logic [1:0]        tout_vld;
    logic [SLOT_W-1:0] tout_addr0, tout_addr1;
    logic [DATA_W-1:0] tout_val;
    logic [1:0]        aout_vld;
    logic [TPL_W-1:0]  aout_tpl;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dfa_unit u_dut (.*);

    // {op[2:0], a[15:0], b[15:0], expected[15:0]}
    localparam logic [50:0] VEC [7] = '{
        {3'd0, 16'h1234, 16'h4321, 16'h5555},
        {3'd0, 16'hFFFF, 16'h0002, 16'h0001},
        {3'd1, 16'h0005, 16'h0007, 16'hFFFE},
        {3'd1, 16'h9000, 16'h1000, 16'h8000},
        {3'd2, 16'hF0F0, 16'h3C3C, 16'h3030},
        {3'd3, 16'hF0F0, 16'h0F01, 16'hFFF1},
        {3'd4, 16'hABCD, 16'h0000, 16'hABCD}
    };

    function automatic logic [SLOT_W+1:0] mkd(logic v, logic e, logic [SLOT_W-1:0] a);
        return {v, e, a};
    endfunction

    function automatic logic [TPL_W+1:0] mks(logic i, logic [TPL_W-1:0] t, logic d);
        return {i, t, d};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(logic [TPL_W-1:0] t, logic [2:0] op, logic [SLOT_W+1:0] d0,
                        logic [SLOT_W+1:0] d1, logic [TPL_W+1:0] s0, logic [TPL_W+1:0] s1);
        ld_vld = 1'b1; ld_tpl = t; ld_op = op;
        ld_dst0 = d0; ld_dst1 = d1; ld_src0 = s0; ld_src1 = s1;
        @(negedge clk);
        ld_vld = 1'b0;
    endtask

    task automatic send(logic [SLOT_W-1:0] s, logic [DATA_W-1:0] v);
        tin_vld = 1'b1; tin_slot = s; tin_val = v;
        @(negedge clk);
        tin_vld = 1'b0;
    endtask

    task automatic ack(logic [TPL_W-1:0] t, logic d);
        ain_vld = 1'b1; ain_tpl = t; ain_dn = d;
        @(negedge clk);
        ain_vld = 1'b0;
    endtask

    task automatic idle3(string req);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(req, {31'd0, fire_vld}, 32'd0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 fire_vld", {31'd0, fire_vld}, 32'd0);
        check("R10 tout_vld", {30'd0, tout_vld}, 32'd0);
        check("R10 aout_vld", {30'd0, aout_vld}, 32'd0);
        check("R10 fire_res", {16'd0, fire_res}, 32'd0);

        // Vector table: entry 0 with external producers and external dst0 at 0xA
        for (int v = 0; v < 7; v++) begin
            logic [2:0]  op;
            logic [15:0] a, b, e;
            {op, a, b, e} = VEC[v];
            load(3'd0, op, mkd(1, 1, 4'hA), '0, mks(0, 0, 0), mks(0, 0, 0));
            send(4'd0, a);
            if (op != 3'd4) send(4'd1, b);
            @(negedge clk);
            check("R5 fire_vld", {31'd0, fire_vld}, 32'd1);
            check("R5 fire_tpl", {29'd0, fire_tpl}, 32'd0);
            check("R4 fire_res", {16'd0, fire_res}, {16'd0, e});
            check("R5 tout_vld", {30'd0, tout_vld}, 32'd1);
            check("R5 tout_addr0", {28'd0, tout_addr0}, 32'hA);
            check("R5 tout_val", {16'd0, tout_val}, {16'd0, e});
            check("R7 aout_vld", {30'd0, aout_vld}, (op == 3'd4) ? 32'd1 : 32'd3);
            check("R7 aout_tpl", {29'd0, aout_tpl}, 32'd0);
            ack(3'd0, 1'b0);
        end

        // R3 missing operand, then R2 second token into a full slot is ignored
        load(3'd0, 3'd0, mkd(1, 1, 4'hA), '0, mks(0, 0, 0), mks(0, 0, 0));
        send(4'd0, 16'd5);
        idle3("R3 no fire with one operand");
        send(4'd0, 16'd9);
        send(4'd1, 16'd3);
        @(negedge clk);
        check("R2 fire_vld", {31'd0, fire_vld}, 32'd1);
        check("R2 kept first value", {16'd0, fire_res}, 32'd8);

        // R8 outstanding external destination blocks refire until acknowledged
        send(4'd0, 16'd1);
        send(4'd1, 16'd1);
        idle3("R8 blocked by outstanding");
        ack(3'd0, 1'b0);
        @(negedge clk);
        check("R8 fire after ack", {31'd0, fire_vld}, 32'd1);
        check("R8 result", {16'd0, fire_res}, 32'd2);
        ack(3'd0, 1'b0);

        // R6/R7 chain: entry 0 PASS -> entry 1 slot A; entry 1 ADD, B external
        load(3'd0, 3'd4, mkd(1, 0, 4'd2), '0, mks(0, 0, 0), '0);
        load(3'd1, 3'd0, mkd(1, 1, 4'h1), '0, mks(1, 3'd0, 0), mks(0, 0, 0));
        send(4'd3, 16'd10);
        send(4'd0, 16'd7);
        @(negedge clk);
        check("R6 producer fire_tpl", {fire_vld, 28'd0, fire_tpl}, {1'b1, 31'd0});
        check("R6 internal dst no tout", {30'd0, tout_vld}, 32'd0);
        check("R7 ext ack from producer", {30'd0, aout_vld}, 32'd1);
        @(negedge clk);
        check("R6 consumer fires next edge", {fire_vld, 28'd0, fire_tpl}, {1'b1, 31'd1});
        check("R6 consumer result", {16'd0, fire_res}, 32'd17);
        check("R6 consumer tout", {26'd0, tout_vld, tout_addr0}, {26'd0, 2'b01, 4'h1});
        check("R7 ack port B only", {27'd0, aout_vld, aout_tpl}, {27'd0, 2'b10, 3'd1});
        send(4'd0, 16'd4);
        @(negedge clk);
        check("R7 internal ack freed producer", {fire_vld, 28'd0, fire_tpl}, {1'b1, 31'd0});
        check("R7 producer result", {16'd0, fire_res}, 32'd4);
        send(4'd3, 16'd1);
        idle3("R8 consumer blocked");
        ack(3'd1, 1'b0);
        @(negedge clk);
        check("R8 consumer after ack", {fire_vld, 28'd0, fire_tpl}, {1'b1, 31'd1});
        check("R8 consumer result", {16'd0, fire_res}, 32'd5);

        // R9 rotation: entry 3 feeds entries 1 and 5 together; 5 must go first
        load(3'd3, 3'd4, mkd(1, 0, 4'd2), mkd(1, 0, 4'd10), mks(0, 0, 0), '0);
        load(3'd1, 3'd4, mkd(1, 1, 4'h1), '0, mks(1, 3'd3, 0), '0);
        load(3'd5, 3'd4, mkd(1, 1, 4'h5), '0, mks(1, 3'd3, 1), '0);
        send(4'd6, 16'h0077);
        @(negedge clk);
        check("R9 source fires", {fire_vld, 28'd0, fire_tpl}, {1'b1, 28'd0, 3'd3});
        @(negedge clk);
        check("R9 entry 5 first", {fire_vld, 28'd0, fire_tpl}, {1'b1, 28'd0, 3'd5});
        check("R9 entry 5 token", {12'd0, tout_addr0, tout_val}, {12'd0, 4'h5, 16'h0077});
        @(negedge clk);
        check("R9 entry 1 second", {fire_vld, 28'd0, fire_tpl}, {1'b1, 28'd0, 3'd1});
        check("R9 entry 1 token", {12'd0, tout_addr0, tout_val}, {12'd0, 4'h1, 16'h0077});
        @(negedge clk);
        check("R9 single fire only", {31'd0, fire_vld}, 32'd0);

        // R1 reload clears a half-filled entry
        load(3'd0, 3'd0, mkd(1, 1, 4'hA), '0, mks(0, 0, 0), mks(0, 0, 0));
        send(4'd0, 16'd2);
        load(3'd0, 3'd0, mkd(1, 1, 4'hA), '0, mks(0, 0, 0), mks(0, 0, 0));
        send(4'd1, 16'd3);
        idle3("R1 reload cleared operand");

        finish_run();
    end

endmodule